// File: doc/BRIEF.md
# Indirect-Window Interrupt Redirection Register Block

This block holds the programmable state of an interrupt router: a 4-bit router ID, a read-only version word and one 64-bit redirection entry per interrupt input pin. Software does not see the table directly. It reaches everything through two bus offsets. One holds an 8-bit select value. The other is a 32-bit data window, and the value in the select register decides what that window shows. Each entry is exposed as two 32-bit halves. An even select value picks the lower half and an odd one picks the upper half.

Delivery logic sits next to this block. It reports a live delivery-status level for each pin, and it pulses per-pin requests to set or clear remote-IRR. Software writes cannot change either of those two bits. Remote-IRR also drops by itself whenever an entry ends up edge-triggered. Each time a write flips an entry's mask bit, a one-cycle notification gives the pin index and the new mask value. Reads return their data one cycle after the request.

Top module: `irq_route_regs`

## Requirements
- R1: After reset the select register reads 0, the ID reads 0, every entry's lower half reads 0x00010000 (only mask bit 16 set) and every upper half reads 0.
- R2: A write to bus offset 0x00 loads the select register with the low 8 bits of the extended write data, and reading offset 0x00 returns it zero-extended.
- R3: With select 0x01 the window reads (pin count − 1) in bits 23:16 and the version code in bits 7:0, which is 0x00170011 with the defaults. Window writes at this select change nothing.
- R4: Selects 0x00 and 0x02 both read the 4-bit ID in bits 27:24 with all other bits zero. A window write at select 0x00 loads the ID from bits 27:24. A window write at select 0x02 is ignored.
- R5: For a select value s ≥ 0x10, the entry index is (s − 0x10) >> 1. Bit 0 of s picks the upper half (1) or the lower half (0). A window write replaces only the addressed half.
- R6: If the entry index computed from a select value is not below the pin count, and for select values 0x03 to 0x0F, a window read returns 0xFFFFFFFF and a window write is discarded.
- R7: A window write leaves remote-IRR (bit 14) and delivery status (bit 12) unchanged. Bit 12 always reads the delivery-status input of that pin as registered on the previous clock edge.
- R8: When an entry's trigger bit 15 is 0 (edge) after a write, its remote-IRR reads 0.
- R9: A read at any bus offset other than 0x00 and 0x10 returns 0, and a write there changes no state.
- R10: The write size is 0 for a byte, 1 for a halfword and 2 or 3 for a word. Byte and halfword writes zero-extend bits 7:0 or 15:0 of the write data before use.
- R11: In the cycle after a window write that changes an entry's mask bit, mask_evt is 1, mask_pin holds the entry index and mask_val holds the new mask value. After any other write, mask_evt stays 0.
- R12: A pulse on rirr_set[i] sets remote-IRR of entry i only when that entry is level-triggered (bit 15 = 1). A pulse on rirr_clr[i] clears it, and the clear wins if both arrive together.
- R13: A read request on bus_rd returns its data on bus_rdata in the next cycle, with bus_rvalid high for exactly that one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte offset within the block |
| bus_size | input | 2 | Write size: 0 byte, 1 halfword, 2/3 word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| dsts_in | input | NPINS | Per-pin delivery-status level from delivery logic |
| rirr_set | input | NPINS | Per-pin remote-IRR set pulse |
| rirr_clr | input | NPINS | Per-pin remote-IRR clear pulse |
| mask_evt | output | 1 | Mask-change notification pulse |
| mask_pin | output | $clog2(NPINS) | Entry whose mask changed |
| mask_val | output | 1 | New mask value |

## Verification
The bench builds the block with its defaults: 24 pins and version code 0x11. With these values, entry selects 0x10 to 0x3F are valid and 0x40 to 0xFF fall outside the table. That makes it practical to sweep all 256 select values after a distinct pattern has been written into every half of every entry. The same sweep covers the reserved selects 0x03 to 0x0F. The status-bit, size-extension and mask-notification cases then run on single pins, with the expected words computed from the bit positions in the requirements.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int ENT_W  = 64;
  localparam int B_DSTS = 12;
  localparam int B_RIRR = 14;
  localparam int B_TRIG = 15;
  localparam int B_MASK = 16;

  localparam logic [7:0] SEL_ID  = 8'h00;
  localparam logic [7:0] SEL_VER = 8'h01;
  localparam logic [7:0] SEL_ARB = 8'h02;
  localparam logic [7:0] SEL_TBL = 8'h10;

  typedef enum logic [2:0] {K_ID, K_VER, K_ARB, K_ENT, K_BAD} sel_kind_e;
  typedef logic [ENT_W-1:0] entry_t;
endpackage

// File: rtl/irq_route_decode.sv
module irq_route_decode
  import irq_route_pkg::*;
#(
  parameter int NPINS = 24,
  localparam int IDX_W = $clog2(NPINS)
) (
  input  logic [7:0]       sel,
  output sel_kind_e        kind,
  output logic [IDX_W-1:0] idx,
  output logic             hi
);
  logic [7:0] off;
  logic [6:0] raw;

  always_comb begin
    off  = sel - SEL_TBL;
    raw  = off[7:1];
    hi   = sel[0];
    idx  = '0;
    kind = K_BAD;
    case (sel)
      SEL_ID:  kind = K_ID;
      SEL_VER: kind = K_VER;
      SEL_ARB: kind = K_ARB;
      default: begin
        if (sel >= SEL_TBL && 32'(raw) < NPINS) begin
          kind = K_ENT;
          idx  = IDX_W'(raw);
        end
      end
    endcase
  end
endmodule

// File: rtl/irq_route_merge.sv
module irq_route_merge
  import irq_route_pkg::*;
(
  input  entry_t      old_e,
  input  logic        hi,
  input  logic [31:0] wdata,
  output entry_t      new_e
);
  always_comb begin
    new_e = old_e;
    if (hi) new_e[63:32] = wdata;
    else    new_e[31:0]  = wdata;
    // status bits owned by delivery logic
    new_e[B_RIRR] = old_e[B_RIRR];
    new_e[B_DSTS] = old_e[B_DSTS];
    if (!new_e[B_TRIG]) new_e[B_RIRR] = 1'b0;
  end
endmodule

// File: rtl/irq_route_table.sv
module irq_route_table
  import irq_route_pkg::*;
#(
  parameter int NPINS = 24,
  localparam int IDX_W = $clog2(NPINS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  entry_t           wr_entry,
  input  logic [NPINS-1:0] dsts_in,
  input  logic [NPINS-1:0] rirr_set,
  input  logic [NPINS-1:0] rirr_clr,
  output entry_t           tbl [NPINS]
);
  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    entry_t nxt;
    always_comb begin
      nxt = tbl[i];
      if (wr_en && 32'(wr_idx) == i) nxt = wr_entry;
      nxt[B_DSTS] = dsts_in[i];
      if (rirr_clr[i])                    nxt[B_RIRR] = 1'b0;
      else if (rirr_set[i] && nxt[B_TRIG]) nxt[B_RIRR] = 1'b1;
    end
    always_ff @(posedge clk) begin
      if (rst) begin
        tbl[i]         <= '0;
        tbl[i][B_MASK] <= 1'b1;
      end else begin
        tbl[i] <= nxt;
      end
    end
  end
endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_route_pkg::*;
#(
  parameter int         NPINS   = 24,
  parameter logic [7:0] VERSION = 8'h11,
  parameter logic [7:0] SEL_OFS = 8'h00,
  parameter logic [7:0] WIN_OFS = 8'h10,
  localparam int        IDX_W   = $clog2(NPINS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [7:0]       bus_addr,
  input  logic [1:0]       bus_size,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic             bus_rvalid,
  input  logic [NPINS-1:0] dsts_in,
  input  logic [NPINS-1:0] rirr_set,
  input  logic [NPINS-1:0] rirr_clr,
  output logic             mask_evt,
  output logic [IDX_W-1:0] mask_pin,
  output logic             mask_val
);
  logic [7:0]       sel_q;
  logic [3:0]       id_q;
  entry_t           tbl_q [NPINS];
  sel_kind_e        kind;
  logic [IDX_W-1:0] idx;
  logic             hi;
  logic [31:0]      wdx;
  entry_t           cur_e;
  entry_t           new_e;
  logic             wr_sel, wr_win, wr_ent;
  logic [31:0]      rd_mux;

  always_comb begin
    case (bus_size)
      2'd0:    wdx = {24'b0, bus_wdata[7:0]};
      2'd1:    wdx = {16'b0, bus_wdata[15:0]};
      default: wdx = bus_wdata;
    endcase
  end

  irq_route_decode #(.NPINS(NPINS)) u_dec (
    .sel(sel_q), .kind(kind), .idx(idx), .hi(hi)
  );

  assign cur_e  = tbl_q[idx];
  assign wr_sel = bus_wr && bus_addr == SEL_OFS;
  assign wr_win = bus_wr && bus_addr == WIN_OFS;
  assign wr_ent = wr_win && kind == K_ENT;

  irq_route_merge u_mrg (
    .old_e(cur_e), .hi(hi), .wdata(wdx), .new_e(new_e)
  );

  irq_route_table #(.NPINS(NPINS)) u_tbl (
    .clk(clk), .rst(rst), .wr_en(wr_ent), .wr_idx(idx), .wr_entry(new_e),
    .dsts_in(dsts_in), .rirr_set(rirr_set), .rirr_clr(rirr_clr), .tbl(tbl_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
      id_q  <= '0;
    end else begin
      if (wr_sel) sel_q <= wdx[7:0];
      if (wr_win && kind == K_ID) id_q <= wdx[27:24];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (bus_addr == SEL_OFS) begin
      rd_mux = {24'b0, sel_q};
    end else if (bus_addr == WIN_OFS) begin
      case (kind)
        K_ID, K_ARB: rd_mux = {4'b0, id_q, 24'b0};
        K_VER:       rd_mux = {8'b0, 8'(NPINS - 1), 8'b0, VERSION};
        K_ENT:       rd_mux = hi ? cur_e[63:32] : cur_e[31:0];
        default:     rd_mux = '1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
      mask_evt   <= 1'b0;
      mask_pin   <= '0;
      mask_val   <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_mux;
      mask_evt <= wr_ent && (new_e[B_MASK] != cur_e[B_MASK]);
      if (wr_ent) begin
        mask_pin <= idx;
        mask_val <= new_e[B_MASK];
      end
    end
  end
endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk
  import irq_route_pkg::*;
#(
  parameter int         NPINS   = 24,
  parameter logic [7:0] SEL_OFS = 8'h00,
  parameter logic [7:0] WIN_OFS = 8'h10,
  localparam int        IDX_W   = $clog2(NPINS)
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic [7:0]       bus_addr,
  input logic             bus_rvalid,
  input logic             mask_evt,
  input logic [IDX_W-1:0] mask_pin,
  input logic [7:0]       sel_q,
  input logic [3:0]       id_q,
  input logic [NPINS-1:0] rirr_clr,
  input entry_t           tbl [NPINS]
);
  a_r13_read_latency: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);
  a_r13_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> !bus_rvalid);
  a_r11_evt_from_write: assert property (@(posedge clk) disable iff (rst)
    mask_evt |-> ($past(bus_wr) && 32'(mask_pin) < NPINS));
  a_r4_id_hold: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_addr == WIN_OFS) |=> $stable(id_q));
  a_r2_sel_hold: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_addr == SEL_OFS) |=> $stable(sel_q));

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    a_r8_edge_no_rirr: assert property (@(posedge clk) disable iff (rst)
      !tbl[i][B_TRIG] |-> !tbl[i][B_RIRR]);
    a_r12_clear_wins: assert property (@(posedge clk) disable iff (rst)
      rirr_clr[i] |=> !tbl[i][B_RIRR]);
  end
endmodule

bind irq_route_regs irq_route_chk #(
  .NPINS(NPINS), .SEL_OFS(SEL_OFS), .WIN_OFS(WIN_OFS)
) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_rvalid(bus_rvalid), .mask_evt(mask_evt), .mask_pin(mask_pin),
  .sel_q(sel_q), .id_q(id_q), .rirr_clr(rirr_clr), .tbl(tbl_q)
);

// File: tb/test_irq_route_regs.sv
module test_irq_route_regs;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 24;

  logic          clk = 0;
  logic          rst = 1;
  logic          bus_wr = 0, bus_rd = 0;
  logic [7:0]    bus_addr = 0;
  logic [1:0]    bus_size = 2;
  logic [31:0]   bus_wdata = 0;
  logic [31:0]   bus_rdata;
  logic          bus_rvalid;
  logic [NP-1:0] dsts_in = 0, rirr_set = 0, rirr_clr = 0;
  logic          mask_evt;
  logic [4:0]    mask_pin;
  logic          mask_val;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] exp_lo [NP];
  logic [31:0] exp_hi [NP];
  logic [3:0]  exp_id;
  logic [31:0] d;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_route_regs i_irq_route_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .dsts_in(dsts_in), .rirr_set(rirr_set),
    .rirr_clr(rirr_clr), .mask_evt(mask_evt), .mask_pin(mask_pin), .mask_val(mask_val)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [1:0] sz, input logic [31:0] v);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_size = sz; bus_wdata = v;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
    v = bus_rdata;
  endtask

  task automatic rd_win(input logic [7:0] s, output logic [31:0] v);
    wr(8'h00, 2'd2, {24'b0, s});
    rd(8'h10, v);
  endtask

  function automatic logic [31:0] pat_lo(input int p);
    logic [7:0] b0, b1, b2, b3;
    b0 = 8'(p + 16); b1 = 8'(p * 13); b2 = 8'(~p); b3 = 8'(p * 7);
    return {b3, b2, b1, b0} & ~32'h0000_5000;
  endfunction

  function automatic logic [31:0] exp_read(input int s);
    int ix;
    if (s == 0 || s == 2) return {4'b0, exp_id, 24'b0};
    if (s == 1) return 32'h0017_0011;
    if (s < 16) return 32'hFFFF_FFFF;
    ix = (s - 16) >> 1;
    if (ix >= NP) return 32'hFFFF_FFFF;
    return (s % 2 == 1) ? exp_hi[ix] : exp_lo[ix];
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    exp_id = 0;

    // R1 reset values
    rd(8'h00, d); chk("R1 select", d, 0);
    rd(8'h10, d); chk("R1 id", d, 0);
    for (int p = 0; p < NP; p++) begin
      rd_win(8'(16 + 2*p), d);     chk("R1 entry low", d, 32'h0001_0000);
      rd_win(8'(16 + 2*p + 1), d); chk("R1 entry high", d, 0);
    end

    // R2 select keeps low byte
    wr(8'h00, 2'd2, 32'h0000_ABCD); rd(8'h00, d); chk("R2 select byte", d, 32'hCD);

    // R3 version read-only
    rd_win(8'h01, d); chk("R3 version", d, 32'h0017_0011);
    wr(8'h10, 2'd2, 32'hFFFF_FFFF); rd(8'h10, d); chk("R3 version after write", d, 32'h0017_0011);

    // R4 id / arbitration
    wr(8'h00, 2'd2, 0); wr(8'h10, 2'd2, 32'hF5FF_FFFF); exp_id = 4'h5;
    rd(8'h10, d); chk("R4 id load", d, 32'h0500_0000);
    wr(8'h00, 2'd2, 2); rd(8'h10, d); chk("R4 arb reads id", d, 32'h0500_0000);
    wr(8'h10, 2'd2, 32'h0A00_0000); rd(8'h10, d); chk("R4 arb write ignored", d, 32'h0500_0000);

    // R5 fill table, R6 out-of-range writes
    for (int p = 0; p < NP; p++) begin
      exp_lo[p] = pat_lo(p);
      exp_hi[p] = 32'(p) * 32'h1111_1111 ^ 32'hC3C3_0000;
      wr(8'h00, 2'd2, 32'(16 + 2*p));     wr(8'h10, 2'd2, exp_lo[p]);
      wr(8'h00, 2'd2, 32'(16 + 2*p + 1)); wr(8'h10, 2'd2, exp_hi[p]);
    end
    wr(8'h00, 2'd2, 32'h05); wr(8'h10, 2'd2, 32'hDEAD_BEEF);
    wr(8'h00, 2'd2, 32'h40); wr(8'h10, 2'd2, 32'hDEAD_BEEF);
    wr(8'h00, 2'd2, 32'hFF); wr(8'h10, 2'd2, 32'hDEAD_BEEF);
    for (int s = 0; s < 256; s++) begin
      rd_win(8'(s), d);
      chk((s >= 16 && s < 16 + 2*NP) ? "R5 entry sweep" : "R6 select sweep", d, exp_read(s));
    end

    // R7 status bits preserved (pin 3, selects 0x16/0x17)
    wr(8'h00, 2'd2, 32'h16); wr(8'h10, 2'd2, 32'h0000_8031);
    @(negedge clk); dsts_in[3] = 1; rirr_set[3] = 1;
    @(negedge clk); rirr_set[3] = 0;
    rd(8'h10, d); chk("R7 status set", d, 32'h0000_D031);
    wr(8'h10, 2'd2, 32'h0000_8042); rd(8'h10, d); chk("R7 write keeps status", d, 32'h0000_D042);
    wr(8'h00, 2'd2, 32'h17); wr(8'h10, 2'd2, 32'h1234_5678);
    wr(8'h00, 2'd2, 32'h16); rd(8'h10, d); chk("R7 high write keeps low", d, 32'h0000_D042);

    // R8 edge clears remote-IRR
    wr(8'h10, 2'd2, 32'h0000_4042); rd(8'h10, d); chk("R8 edge clears rirr", d, 32'h0000_1042);
    @(negedge clk); dsts_in[3] = 0;
    @(negedge clk); rd(8'h10, d); chk("R7 dsts follows input", d, 32'h0000_0042);

    // R12 set only when level, clear wins
    @(negedge clk); rirr_set[3] = 1; @(negedge clk); rirr_set[3] = 0;
    rd(8'h10, d); chk("R12 set ignored on edge", d, 32'h0000_0042);
    wr(8'h10, 2'd2, 32'h0000_8042);
    @(negedge clk); rirr_set[3] = 1; @(negedge clk); rirr_set[3] = 0;
    rd(8'h10, d); chk("R12 set on level", d, 32'h0000_C042);
    @(negedge clk); rirr_set[3] = 1; rirr_clr[3] = 1;
    @(negedge clk); rirr_set[3] = 0; rirr_clr[3] = 0;
    rd(8'h10, d); chk("R12 clear wins", d, 32'h0000_8042);

    // R9 other offsets
    rd(8'h04, d); chk("R9 read 0x04", d, 0);
    rd(8'hF0, d); chk("R9 read 0xF0", d, 0);
    wr(8'h20, 2'd2, 32'hFFFF_FFFF); wr(8'h08, 2'd2, 32'h0000_0011);
    rd(8'h00, d); chk("R9 select untouched", d, 32'h16);
    rd(8'h10, d); chk("R9 entry untouched", d, 32'h0000_8042);

    // R10 size extension (pin 5, select 0x1A)
    wr(8'h00, 2'd0, 32'hFFFF_FF1A); rd(8'h00, d); chk("R10 byte select", d, 32'h1A);
    wr(8'h10, 2'd0, 32'hFFFF_FF77); rd(8'h10, d); chk("R10 byte window", d, 32'h0000_0077);
    wr(8'h10, 2'd1, 32'hFFFF_8123); rd(8'h10, d); chk("R10 half window", d, 32'h0000_8123);

    // R11 mask notification (pin 7, select 0x1E)
    wr(8'h00, 2'd2, 32'h1E);
    wr(8'h10, 2'd2, 32'h0000_0011);
    wr(8'h10, 2'd2, 32'h0001_0011);
    chk("R11 evt on set", {31'b0, mask_evt}, 1);
    chk("R11 pin", {27'b0, mask_pin}, 7);
    chk("R11 val set", {31'b0, mask_val}, 1);
    wr(8'h10, 2'd2, 32'h0001_0022); chk("R11 no evt unchanged", {31'b0, mask_evt}, 0);
    wr(8'h00, 2'd2, 32'h1F); wr(8'h10, 2'd2, 32'hFFFF_FFFF);
    chk("R11 no evt high half", {31'b0, mask_evt}, 0);
    wr(8'h00, 2'd2, 32'h1E); wr(8'h10, 2'd2, 32'h0000_0022);
    chk("R11 evt on clear", {31'b0, mask_evt}, 1);
    chk("R11 val clear", {31'b0, mask_val}, 0);

    // R13 read handshake
    @(negedge clk); chk("R13 idle rvalid", {31'b0, bus_rvalid}, 0);
    @(negedge clk); bus_rd = 1; bus_addr = 8'h00;
    @(negedge clk); bus_rd = 0;
    chk("R13 rvalid", {31'b0, bus_rvalid}, 1);
    chk("R13 data", bus_rdata, 32'h1E);
    @(negedge clk); chk("R13 rvalid one cycle", {31'b0, bus_rvalid}, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule